// File: doc/BRIEF.md
# Packet DRAM Read Transaction Sequencer

This block sits on the controller side of a packet-oriented DRAM. It turns one read request (bank, row, column, auto-precharge flag) into a timed series of packet strobes. First comes an address packet. It is followed by a group of four more items: a read strobe, a column packet, a terminate packet and a four-beat data-capture window. All positions are counted in packet cycles. The spacing inside that group is fixed by configuration. The whole group moves as one unit relative to the address packet.

A small table keeps, for each bank, whether the bank is open and which row it holds. The table decides whether a request is a page hit or a precharged-bank access. A page hit is sent as a plain read, with a strobe offset of `cfg_rsr_i`. An access to a precharged bank is sent as a combined activate-plus-read, and its whole group is pushed back by two further packet cycles to leave room for row activation. The block does not handle a request to an open bank whose open row is a different row. It rejects such a request and raises an error pulse.

The sequencer works on one request at a time. It holds `busy_o` until the last data beat has been captured. It samples the timing configuration when it accepts a request, so changing the configuration while a transaction is running has no effect on that transaction.

Top module: `pkt_read_sequencer`

## Requirements
- R1: After a synchronous active-high reset, every bank is precharged, `busy_o` and `err_o` are low, every packet strobe and `dwin_o` are low, and `req_ready_o` is high.
- R2: A request is classified at acceptance from the bank table. `cmd_o` is 2'd0 for a page hit without auto-precharge, 2'd1 for a page hit with auto-precharge, 2'd2 for activate-plus-read to a precharged bank without auto-precharge, and 2'd3 for activate-plus-read with auto-precharge. `cmd_o` is valid while `req_pkt_o` is high.
- R3: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is the inverse of `busy_o`. `req_pkt_o` is high for one cycle, the second cycle after the accepting edge (one register stage after the busy flag). A request presented while busy is ignored and leaves the bank table unchanged.
- R4: `strb_pkt_o` rises R cycles after `req_pkt_o`. R equals `cfg_rsr_i` for a page hit and `cfg_rsr_i`+2 for activate-plus-read.
- R5: `dwin_o` is high for exactly four consecutive cycles. The first of these cycles comes `cfg_sdr_i` cycles after `strb_pkt_o`, and `beat_o` counts 0, 1, 2, 3 across them.
- R6: `col_pkt_o` rises `cfg_cdr_i` cycles before the first data beat. If that point would fall before the address packet, it saturates to the address packet cycle.
- R7: `term_pkt_o` rises `cfg_tdr_i` cycles before the data end (the cycle after the fourth beat). A value of zero is treated as one. An offset that would fall before the address packet saturates to the address packet cycle.
- R8: An activate-plus-read leaves its bank open on the requested row, and a page hit leaves the table unchanged. A later request to that bank and row is therefore a hit.
- R9: When a transaction with auto-precharge completes, its bank is marked precharged, so the next request to that bank is an activate-plus-read.
- R10: A request accepted by the handshake that targets an open bank holding a different row produces a one-cycle `err_o` pulse in the cycle after the edge that samples it. It produces no packets and leaves `busy_o` low.
- R11: `busy_o` rises in the cycle after acceptance and falls in the cycle after the fourth data beat. Every packet strobe of a transaction falls within the busy interval.
- R12: `pkt_bank_o`, `pkt_row_o` and `pkt_col_o` hold the accepted request's fields throughout the transaction. Timing configuration is sampled only at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Packet-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Read request present |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_bank_i | input | BW | Target bank |
| req_row_i | input | RW | Target row |
| req_col_i | input | CW | Target column |
| req_ap_i | input | 1 | Auto-precharge after the read |
| cfg_rsr_i | input | TW | Address packet to strobe offset for a page hit |
| cfg_sdr_i | input | TW | Strobe to first data beat offset |
| cfg_cdr_i | input | TW | Column packet to first data beat offset |
| cfg_tdr_i | input | TW | Terminate packet to data end offset |
| busy_o | output | 1 | Transaction in progress |
| err_o | output | 1 | One-cycle pulse for a rejected row conflict |
| cmd_o | output | 2 | Command kind of the running transaction |
| pkt_bank_o | output | BW | Bank of the running transaction |
| pkt_row_o | output | RW | Row of the running transaction |
| pkt_col_o | output | CW | Column of the running transaction |
| req_pkt_o | output | 1 | Address packet strobe |
| strb_pkt_o | output | 1 | Read strobe packet |
| col_pkt_o | output | 1 | Column packet |
| term_pkt_o | output | 1 | Terminate packet |
| dwin_o | output | 1 | Data-capture window |
| beat_o | output | 2 | Data beat index inside the window |

## Verification
The main sweep covers every combination of the four offsets over small ranges, and does so in both bank states. This separates a correct two-cycle shift of the group from a shift applied to only part of it. Column and terminate offsets that are larger than the data start exercise the saturation rule, and a terminate offset of zero exercises the minimum of one. Alternating an activate-plus-read with a hit that auto-precharges checks that the bank table opens and closes in the right order. Conflict requests, and requests held high while the sequencer is busy with a changed configuration, separate requests that are rejected or ignored from requests that are actually sequenced.

// File: rtl/pkt_rd_pkg.sv
package pkt_rd_pkg;
  localparam int unsigned BEATS  = 4;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic [1:0] {
    CMD_READ        = 2'd0,
    CMD_READ_AP     = 2'd1,
    CMD_ACT_READ    = 2'd2,
    CMD_ACT_READ_AP = 2'd3
  } rd_cmd_e;

  typedef enum logic [1:0] {
    CLS_HIT      = 2'd0,
    CLS_CLOSED   = 2'd1,
    CLS_CONFLICT = 2'd2
  } req_cls_e;
endpackage

// File: rtl/pkt_bank_table.sv
module pkt_bank_table
  import pkt_rd_pkg::*;
#(
  parameter int unsigned NB = 4,
  parameter int unsigned RW = 4,
  localparam int unsigned BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] lk_bank,
  input  logic [RW-1:0] lk_row,
  output req_cls_e      lk_cls,
  input  logic          open_we,
  input  logic [BW-1:0] open_bank,
  input  logic [RW-1:0] open_row,
  input  logic          close_we,
  input  logic [BW-1:0] close_bank
);
  logic [NB-1:0] open_vec;
  logic [RW-1:0] row_arr [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic          open_r;
    logic [RW-1:0] row_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        open_r <= 1'b0;
        row_r  <= '0;
      end else if (open_we && open_bank == BW'(g)) begin
        open_r <= 1'b1;
        row_r  <= open_row;
      end else if (close_we && close_bank == BW'(g)) begin
        open_r <= 1'b0;
      end
    end
    assign open_vec[g] = open_r;
    assign row_arr[g]  = row_r;
  end

  always_comb begin
    if (!open_vec[lk_bank])              lk_cls = CLS_CLOSED;
    else if (row_arr[lk_bank] == lk_row) lk_cls = CLS_HIT;
    else                                 lk_cls = CLS_CONFLICT;
  end
endmodule

// File: rtl/pkt_sched_calc.sv
module pkt_sched_calc
  import pkt_rd_pkg::*;
#(
  parameter int unsigned TW        = 4,
  parameter int unsigned ACT_EXTRA = 2,
  localparam int unsigned TTW = TW + 3
) (
  input  logic [TW-1:0]  cfg_rsr,
  input  logic [TW-1:0]  cfg_sdr,
  input  logic [TW-1:0]  cfg_cdr,
  input  logic [TW-1:0]  cfg_tdr,
  input  logic           act,
  output logic [TTW-1:0] t_strb,
  output logic [TTW-1:0] t_col,
  output logic [TTW-1:0] t_term,
  output logic [TTW-1:0] t_data
);
  logic [TTW-1:0] r_eff, t_end, c_ext, d_min;

  always_comb begin
    r_eff  = TTW'(cfg_rsr) + (act ? TTW'(ACT_EXTRA) : '0);
    t_data = r_eff + TTW'(cfg_sdr);
    t_end  = t_data + TTW'(BEATS);
    c_ext  = TTW'(cfg_cdr);
    t_col  = (c_ext > t_data) ? '0 : t_data - c_ext;
    d_min  = (cfg_tdr == '0) ? TTW'(1) : TTW'(cfg_tdr);
    t_term = (d_min > t_end) ? '0 : t_end - d_min;
    t_strb = r_eff;
  end
endmodule

// File: rtl/pkt_timeline.sv
module pkt_timeline
  import pkt_rd_pkg::*;
#(
  parameter int unsigned TTW = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TTW-1:0]    t_strb,
  input  logic [TTW-1:0]    t_col,
  input  logic [TTW-1:0]    t_term,
  input  logic [TTW-1:0]    t_data,
  output logic              req_o,
  output logic              strb_o,
  output logic              col_o,
  output logic              term_o,
  output logic              dwin_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o
);
  logic           run_q;
  logic [TTW-1:0] cnt_q, ts_q, tc_q, tt_q, td_q, tend_q;
  logic           in_data;

  assign in_data = run_q && (cnt_q >= td_q) && (cnt_q <= tend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      ts_q   <= '0;
      tc_q   <= '0;
      tt_q   <= '0;
      td_q   <= '0;
      tend_q <= '0;
      req_o  <= 1'b0;
      strb_o <= 1'b0;
      col_o  <= 1'b0;
      term_o <= 1'b0;
      dwin_o <= 1'b0;
      beat_o <= '0;
      last_o <= 1'b0;
    end else begin
      req_o  <= run_q && (cnt_q == '0);
      strb_o <= run_q && (cnt_q == ts_q);
      col_o  <= run_q && (cnt_q == tc_q);
      term_o <= run_q && (cnt_q == tt_q);
      dwin_o <= in_data;
      beat_o <= in_data ? BEAT_W'(cnt_q - td_q) : '0;
      last_o <= run_q && (cnt_q == tend_q);
      if (start) begin
        run_q  <= 1'b1;
        cnt_q  <= '0;
        ts_q   <= t_strb;
        tc_q   <= t_col;
        tt_q   <= t_term;
        td_q   <= t_data;
        tend_q <= t_data + TTW'(BEATS - 1);
      end else if (run_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == tend_q) run_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pkt_read_sequencer.sv
module pkt_read_sequencer
  import pkt_rd_pkg::*;
#(
  parameter int unsigned NB        = 4,
  parameter int unsigned RW        = 4,
  parameter int unsigned CW        = 3,
  parameter int unsigned TW        = 4,
  parameter int unsigned ACT_EXTRA = 2,
  localparam int unsigned BW  = $clog2(NB),
  localparam int unsigned TTW = TW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [BW-1:0] req_bank_i,
  input  logic [RW-1:0] req_row_i,
  input  logic [CW-1:0] req_col_i,
  input  logic          req_ap_i,
  input  logic [TW-1:0] cfg_rsr_i,
  input  logic [TW-1:0] cfg_sdr_i,
  input  logic [TW-1:0] cfg_cdr_i,
  input  logic [TW-1:0] cfg_tdr_i,
  output logic          busy_o,
  output logic          err_o,
  output logic [1:0]    cmd_o,
  output logic [BW-1:0] pkt_bank_o,
  output logic [RW-1:0] pkt_row_o,
  output logic [CW-1:0] pkt_col_o,
  output logic          req_pkt_o,
  output logic          strb_pkt_o,
  output logic          col_pkt_o,
  output logic          term_pkt_o,
  output logic          dwin_o,
  output logic [1:0]    beat_o
);
  req_cls_e       cls;
  logic           take, accept, reject, need_act, last;
  logic           busy_q, err_q, ap_q;
  rd_cmd_e        cmd_q;
  logic [BW-1:0]  bank_q;
  logic [RW-1:0]  row_q;
  logic [CW-1:0]  col_q;
  logic [TTW-1:0] t_strb, t_col, t_term, t_data;

  assign take     = req_valid_i && !busy_q;
  assign accept   = take && (cls != CLS_CONFLICT);
  assign reject   = take && (cls == CLS_CONFLICT);
  assign need_act = (cls == CLS_CLOSED);

  pkt_bank_table #(.NB(NB), .RW(RW)) i_table (
    .clk        (clk),
    .rst        (rst),
    .lk_bank    (req_bank_i),
    .lk_row     (req_row_i),
    .lk_cls     (cls),
    .open_we    (accept && need_act),
    .open_bank  (req_bank_i),
    .open_row   (req_row_i),
    .close_we   (last && ap_q),
    .close_bank (bank_q)
  );

  pkt_sched_calc #(.TW(TW), .ACT_EXTRA(ACT_EXTRA)) i_calc (
    .cfg_rsr (cfg_rsr_i),
    .cfg_sdr (cfg_sdr_i),
    .cfg_cdr (cfg_cdr_i),
    .cfg_tdr (cfg_tdr_i),
    .act     (need_act),
    .t_strb  (t_strb),
    .t_col   (t_col),
    .t_term  (t_term),
    .t_data  (t_data)
  );

  pkt_timeline #(.TTW(TTW)) i_line (
    .clk    (clk),
    .rst    (rst),
    .start  (accept),
    .t_strb (t_strb),
    .t_col  (t_col),
    .t_term (t_term),
    .t_data (t_data),
    .req_o  (req_pkt_o),
    .strb_o (strb_pkt_o),
    .col_o  (col_pkt_o),
    .term_o (term_pkt_o),
    .dwin_o (dwin_o),
    .beat_o (beat_o),
    .last_o (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      ap_q   <= 1'b0;
      cmd_q  <= CMD_READ;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      err_q <= reject;
      if (accept) begin
        busy_q <= 1'b1;
        ap_q   <= req_ap_i;
        cmd_q  <= rd_cmd_e'({need_act, req_ap_i});
        bank_q <= req_bank_i;
        row_q  <= req_row_i;
        col_q  <= req_col_i;
      end else if (last) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign req_ready_o = !busy_q;
  assign busy_o      = busy_q;
  assign err_o       = err_q;
  assign cmd_o       = cmd_q;
  assign pkt_bank_o  = bank_q;
  assign pkt_row_o   = row_q;
  assign pkt_col_o   = col_q;
endmodule

// File: rtl/pkt_read_sequencer_chk.sv
module pkt_read_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       busy_o,
  input logic       err_o,
  input logic       req_pkt_o,
  input logic       strb_pkt_o,
  input logic       dwin_o,
  input logic [1:0] beat_o
);
  // R3: the address packet follows an accepting handshake by two edges
  p_req_delay_r3: assert property (@(posedge clk) disable iff (rst)
    req_pkt_o |-> $past(req_valid_i && req_ready_o, 2));

  // R5: the capture window advances one beat per cycle
  p_beat_step_r5: assert property (@(posedge clk) disable iff (rst)
    (dwin_o && beat_o != 2'd3) |=> (dwin_o && beat_o == 2'($past(beat_o) + 2'd1)));

  // R5: the window opens on beat zero
  p_beat_start_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dwin_o) |-> (beat_o == 2'd0));

  // R10: an error pulse comes only from a request sampled while idle
  p_err_cause_r10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(req_valid_i && !busy_o));

  // R10: a rejected request never starts a transaction
  p_err_idle_r10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !busy_o);

  // R11: busy ends only right after the fourth beat
  p_busy_end_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(dwin_o && beat_o == 2'd3));

  // R11: strobes stay inside the busy interval
  p_strobe_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (strb_pkt_o || req_pkt_o || dwin_o) |-> busy_o);
endmodule

bind pkt_read_sequencer pkt_read_sequencer_chk i_chk (.*);

// File: tb/test_pkt_read_sequencer.sv
`timescale 1ns/1ps
module test_pkt_read_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid_i = 1'b0;
  logic       req_ready_o;
  logic [1:0] req_bank_i = '0;
  logic [3:0] req_row_i = '0;
  logic [2:0] req_col_i = '0;
  logic       req_ap_i = 1'b0;
  logic [3:0] cfg_rsr_i = '0, cfg_sdr_i = '0, cfg_cdr_i = '0, cfg_tdr_i = '0;
  logic       busy_o, err_o;
  logic [1:0] cmd_o;
  logic [1:0] pkt_bank_o;
  logic [3:0] pkt_row_o;
  logic [2:0] pkt_col_o;
  logic       req_pkt_o, strb_pkt_o, col_pkt_o, term_pkt_o, dwin_o;
  logic [1:0] beat_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  pkt_read_sequencer i_pkt_read_sequencer (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic txn(input int b, input int r, input int c, input bit ap,
                     input int rsr, input int sdr, input int cdr, input int tdr,
                     input int ecmd, input bit noise);
    int rr, td, tc, dm, tt;
    int nreq, nstrb, ncol, nterm, ndata, nfall;
    int kreq, kstrb, kcol, kterm, kbeat;
    int scmd, sbank, srow, scol;
    bit beat_ok;
    rr = rsr + (ecmd >= 2 ? 2 : 0);
    td = rr + sdr;
    tc = (cdr > td) ? 0 : td - cdr;
    dm = (tdr == 0) ? 1 : tdr;
    tt = (dm > td + 4) ? 0 : td + 4 - dm;
    nreq = -1; nstrb = -1; ncol = -1; nterm = -1; ndata = -1; nfall = -1;
    kreq = 0; kstrb = 0; kcol = 0; kterm = 0; kbeat = 0;
    scmd = -1; sbank = -1; srow = -1; scol = -1; beat_ok = 1'b1;
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R3 ready before request", int'(req_ready_o), 1);
    req_valid_i = 1'b1; req_bank_i = 2'(b); req_row_i = 4'(r); req_col_i = 3'(c);
    req_ap_i = ap;
    cfg_rsr_i = 4'(rsr); cfg_sdr_i = 4'(sdr); cfg_cdr_i = 4'(cdr); cfg_tdr_i = 4'(tdr);
    @(posedge clk);
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      if (n == 0) begin
        chk(err_o == 1'b0, "R10 no error on valid request", int'(err_o), 0);
        if (noise) begin
          req_bank_i = 2'(b + 1); req_row_i = 4'd9; req_col_i = 3'd7; req_ap_i = 1'b0;
          cfg_rsr_i = 4'd9; cfg_sdr_i = 4'd1; cfg_cdr_i = 4'd0; cfg_tdr_i = 4'd7;
        end else begin
          req_valid_i = 1'b0;
        end
      end
      if (req_pkt_o) begin
        kreq++;
        if (nreq < 0) begin
          nreq = n; scmd = int'(cmd_o); sbank = int'(pkt_bank_o); srow = int'(pkt_row_o);
        end
      end
      if (strb_pkt_o) begin kstrb++; if (nstrb < 0) nstrb = n; end
      if (col_pkt_o) begin kcol++; if (ncol < 0) begin ncol = n; scol = int'(pkt_col_o); end end
      if (term_pkt_o) begin kterm++; if (nterm < 0) nterm = n; end
      if (dwin_o) begin
        if (ndata < 0) ndata = n;
        if (int'(beat_o) != n - ndata) beat_ok = 1'b0;
        kbeat++;
      end
      if (!busy_o) begin
        nfall = n;
        req_valid_i = 1'b0;
        break;
      end
    end
    chk(nreq == 1 && kreq == 1, "R3 address packet one cycle after busy", nreq, 1);
    chk(scmd == ecmd, "R2 command kind", scmd, ecmd);
    chk(nstrb - nreq == rr && kstrb == 1, "R4 strobe offset", nstrb - nreq, rr);
    chk(ndata - nstrb == sdr, "R5 strobe to data", ndata - nstrb, sdr);
    chk(kbeat == 4 && beat_ok, "R5 four ordered beats", kbeat, 4);
    chk(ncol - nreq == tc && kcol == 1, "R6 column position", ncol - nreq, tc);
    chk(nterm - nreq == tt && kterm == 1, "R7 terminate position", nterm - nreq, tt);
    chk(nfall - nreq == td + 4, "R11 busy end", nfall - nreq, td + 4);
    chk(sbank == b && srow == r && scol == c, "R12 request fields held", srow, r);
  endtask

  task automatic conflict(input int b, input int r);
    int kpk;
    kpk = 0;
    @(negedge clk);
    req_valid_i = 1'b1; req_bank_i = 2'(b); req_row_i = 4'(r); req_ap_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(err_o == 1'b1, "R10 error pulse", int'(err_o), 1);
    chk(busy_o == 1'b0, "R10 stays idle", int'(busy_o), 0);
    @(negedge clk);
    chk(err_o == 1'b0, "R10 pulse is one cycle", int'(err_o), 0);
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      if (req_pkt_o || strb_pkt_o || dwin_o || busy_o) kpk++;
    end
    chk(kpk == 0, "R10 no packets after conflict", kpk, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b0 && err_o == 1'b0, "R1 idle after reset", int'(busy_o), 0);
    chk(!req_pkt_o && !strb_pkt_o && !col_pkt_o && !term_pkt_o && !dwin_o,
        "R1 strobes low after reset", int'(dwin_o), 0);
    chk(req_ready_o == 1'b1, "R1 ready after reset", int'(req_ready_o), 1);

    // Sweep: open bank with activate-plus-read, then hit with auto-precharge (R8, R9)
    for (int rsr = 0; rsr < 4; rsr++)
      for (int sdr = 0; sdr < 4; sdr++)
        for (int cdr = 0; cdr < 6; cdr++)
          for (int tdr = 0; tdr < 6; tdr++) begin
            int idx, b, r, c;
            idx = ((rsr * 4 + sdr) * 6 + cdr) * 6 + tdr;
            b = idx % 4; r = (idx * 5) % 16; c = idx % 7;
            if (idx % 7 == 3) begin
              txn(b, r, c, 1'b1, rsr, sdr, cdr, tdr, 3, 1'b0);
            end else begin
              txn(b, r, c, 1'b0, rsr, sdr, cdr, tdr, 2, 1'b0);
              txn(b, r, c + 1, 1'b1, rsr, sdr, cdr, tdr, 1, 1'b0);
            end
          end

    // R8 and R10: open row stays open through plain hits, conflicts rejected
    txn(0, 5, 1, 1'b0, 2, 1, 1, 2, 2, 1'b0);
    conflict(0, 6);
    txn(0, 5, 2, 1'b0, 1, 2, 3, 1, 0, 1'b0);
    txn(0, 5, 3, 1'b1, 0, 0, 0, 0, 1, 1'b0);
    // R9: after auto-precharge the other row opens freshly
    txn(0, 6, 4, 1'b1, 3, 3, 5, 5, 3, 1'b0);

    // R3 and R12: request and config changes while busy are ignored
    txn(2, 7, 2, 1'b0, 1, 2, 2, 3, 2, 1'b1);
    txn(3, 3, 1, 1'b1, 0, 1, 1, 1, 3, 1'b0);
    txn(2, 7, 5, 1'b1, 0, 1, 2, 2, 1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule